// File: doc/BRIEF.md
# System Control Register File

This block is a bank of 32-bit control and status words behind a 4 KB byte-addressed window. A simple synchronous bus presents a byte address, a read strobe, a write strobe and write data; the word index is the byte address with its two low bits dropped. Written words are stored and returned on later reads. Read data is registered and appears in the cycle after the read strobe.

One control offset also acts as a request port for the chip. A write of 1 or 2 there produces a single-cycle system reset request, and a write of 3 produces a single-cycle shutdown request. The logic that sequences reset and power consumes these pulses. Three status offsets return their stored word with bits 29 and 28 forced high on every read. A set of words comes out of reset with fixed identification values. Any access outside the implemented word range is dropped safely and pulses an error flag.

Top module: `sysctl_regfile`

## Requirements
- R1: While reset is held, read data, both request outputs and the error flag are zero. After reset, word 0x40 holds 0x05F20121, word 0x41 holds 0x00000002, word 0x42 holds 0x05F30121, word 0x43 holds 0x05F40121, and every other word holds zero.
- R2: A write to an in-range word stores the full 32-bit value. A read returns the stored word on `bus_rdata` in the cycle after the read strobe. `bus_rdata` keeps its value in cycles with no read strobe.
- R3: A write whose word index is 512 or more changes no stored word. For example, byte offset 0x800 does not alias onto word 0.
- R4: A read whose word index is 512 or more returns zero.
- R5: Reads at byte offsets 0x100, 0x108 and 0x10C return the stored word ORed with 0x30000000. Other offsets, such as 0x104, return the stored word unaltered.
- R6: A write of value 1 or 2 to byte offset 0xF00 drives `sys_reset_req` high for exactly one cycle, in the cycle after the write.
- R7: A write of value 3 to byte offset 0xF00 drives `sys_off_req` high for exactly one cycle, in the cycle after the write.
- R8: No request is raised by a write of any other value to 0xF00, by a read of 0xF00, or by a write of 1, 2 or 3 to any other offset.
- R9: The control-offset decode does not depend on the range check. A control write is stored only when its word index is in range. With the default 512 words, offset 0xF00 (word 960) is out of range: the request still fires, the word is not stored, and a read of 0xF00 returns zero.
- R10: `bus_err` is high for one cycle after any read or write whose word index is 512 or more, and low after in-range accesses and idle cycles.
- R11: Address bits 1:0 are ignored, so byte address 0x013 reaches the same word as 0x010.
- R12: `sys_reset_req` and `sys_off_req` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address within the window |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| sys_reset_req | output | 1 | One-cycle system reset request |
| sys_off_req | output | 1 | One-cycle shutdown request |
| bus_err | output | 1 | One-cycle out-of-range access flag |

## Verification
The bench builds the block with its default parameters: a 12-bit window, 512 words, the control offset at 0xF00, and three forced offsets. With these values the control offset lies past the last implemented word. This brings the R9 case within reach, where a request fires while the write itself is dropped and flagged. The defaults also make word 511 and word 512 the storage boundary, which the bench tests from both sides, together with the 0x800 offset that would alias onto word 0 if the range check were missing.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

   localparam int WORD_W       = 32;
   localparam int NUM_DEFAULTS = 4;

   // word index / value pairs loaded at reset (R1)
   localparam int          DEF_IDX [NUM_DEFAULTS] = '{'h40, 'h41, 'h42, 'h43};
   localparam logic [31:0] DEF_VAL [NUM_DEFAULTS] =
      '{32'h05F2_0121, 32'h0000_0002, 32'h05F3_0121, 32'h05F4_0121};

   function automatic logic [WORD_W-1:0] reset_value(input int idx);
      logic [WORD_W-1:0] v;
      v = '0;
      for (int k = 0; k < NUM_DEFAULTS; k++) begin
         if (DEF_IDX[k] == idx) v = DEF_VAL[k];
      end
      return v;
   endfunction

   typedef enum logic [1:0] {
      REQ_NONE  = 2'd0,
      REQ_RESET = 2'd1,
      REQ_OFF   = 2'd2
   } req_kind_e;

endpackage

// File: rtl/sysctl_addr_dec.sv
module sysctl_addr_dec #(
   parameter int                           ADDR_W         = 12,
   parameter int                           NUM_WORDS      = 512,
   parameter logic [ADDR_W-1:0]            CTRL_OFFSET    = 12'hF00,
   parameter int                           NUM_FORCED     = 3,
   parameter logic [NUM_FORCED*ADDR_W-1:0] FORCED_OFFSETS = {12'h10C, 12'h108, 12'h100},
   localparam int                          IDX_W          = ADDR_W - 2
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [IDX_W-1:0]  idx,
   output logic              in_range,
   output logic              ctrl_hit,
   output logic              force_hit
);

   localparam logic [IDX_W:0]   LIMIT    = (IDX_W+1)'(NUM_WORDS);
   localparam logic [IDX_W-1:0] CTRL_IDX = CTRL_OFFSET[ADDR_W-1:2];

   logic [NUM_FORCED-1:0] hits;
   logic                  unused_lowbits;

   assign idx            = addr[ADDR_W-1:2];
   assign unused_lowbits = ^addr[1:0];
   assign in_range       = ({1'b0, idx} < LIMIT);
   assign ctrl_hit       = (idx == CTRL_IDX);

   for (genvar g = 0; g < NUM_FORCED; g++) begin : g_force
      assign hits[g] = (idx == FORCED_OFFSETS[g*ADDR_W+2 +: IDX_W]);
   end

   assign force_hit = |hits;

endmodule

// File: rtl/sysctl_store.sv
module sysctl_store #(
   parameter int  DATA_W    = 32,
   parameter int  NUM_WORDS = 512,
   localparam int SEL_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [SEL_W-1:0]  wsel,
   input  logic [DATA_W-1:0] wdata,
   input  logic [SEL_W-1:0]  rsel,
   output logic [DATA_W-1:0] rword
);

   logic [DATA_W-1:0] mem [NUM_WORDS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_WORDS; i++) begin
            mem[i] <= DATA_W'(sysctl_pkg::reset_value(i));
         end
      end else if (we) begin
         mem[wsel] <= wdata;
      end
   end

   assign rword = mem[rsel];

endmodule

// File: rtl/sysctl_req.sv
module sysctl_req #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              ctrl_hit,
   input  logic [DATA_W-1:0] wdata,
   output logic              reset_req,
   output logic              off_req
);
   import sysctl_pkg::*;

   req_kind_e kind;

   // reset wins over shutdown should both ever decode
   always_comb begin
      kind = REQ_NONE;
      if (wr && ctrl_hit) begin
         if (wdata == DATA_W'(1) || wdata == DATA_W'(2)) kind = REQ_RESET;
         else if (wdata == DATA_W'(3))                    kind = REQ_OFF;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reset_req <= 1'b0;
         off_req   <= 1'b0;
      end else begin
         reset_req <= (kind == REQ_RESET);
         off_req   <= (kind == REQ_OFF);
      end
   end

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile #(
   parameter int                           ADDR_W         = 12,
   parameter int                           DATA_W         = 32,
   parameter int                           NUM_WORDS      = 512,
   parameter logic [ADDR_W-1:0]            CTRL_OFFSET    = 12'hF00,
   parameter int                           NUM_FORCED     = 3,
   parameter logic [NUM_FORCED*ADDR_W-1:0] FORCED_OFFSETS = {12'h10C, 12'h108, 12'h100},
   parameter logic [DATA_W-1:0]            FORCE_MASK     = 32'h3000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              sys_reset_req,
   output logic              sys_off_req,
   output logic              bus_err
);

   localparam int IDX_W = ADDR_W - 2;
   localparam int SEL_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

   // elaboration-time parameter checks
   if (ADDR_W < 3)
      $error("sysctl_regfile: ADDR_W too small");
   if (DATA_W < sysctl_pkg::WORD_W)
      $error("sysctl_regfile: DATA_W below reset-value width");
   if (NUM_WORDS < 2 || NUM_WORDS > (1 << IDX_W))
      $error("sysctl_regfile: NUM_WORDS outside window");
   if (SEL_W > IDX_W)
      $error("sysctl_regfile: select width exceeds index width");
   if (NUM_FORCED < 1)
      $error("sysctl_regfile: NUM_FORCED must be at least 1");

   logic [IDX_W-1:0]  idx;
   logic              in_range, ctrl_hit, force_hit;
   logic [DATA_W-1:0] rword;
   logic [DATA_W-1:0] rd_next;

   sysctl_addr_dec #(
      .ADDR_W        (ADDR_W),
      .NUM_WORDS     (NUM_WORDS),
      .CTRL_OFFSET   (CTRL_OFFSET),
      .NUM_FORCED    (NUM_FORCED),
      .FORCED_OFFSETS(FORCED_OFFSETS)
   ) i_dec (
      .addr     (bus_addr),
      .idx      (idx),
      .in_range (in_range),
      .ctrl_hit (ctrl_hit),
      .force_hit(force_hit)
   );

   sysctl_store #(
      .DATA_W   (DATA_W),
      .NUM_WORDS(NUM_WORDS)
   ) i_store (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (bus_wr && in_range),
      .wsel (idx[SEL_W-1:0]),
      .wdata(bus_wdata),
      .rsel (idx[SEL_W-1:0]),
      .rword(rword)
   );

   sysctl_req #(
      .DATA_W(DATA_W)
   ) i_req (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (bus_wr),
      .ctrl_hit (ctrl_hit),
      .wdata    (bus_wdata),
      .reset_req(sys_reset_req),
      .off_req  (sys_off_req)
   );

   always_comb begin
      rd_next = '0;
      if (in_range) rd_next = rword | (force_hit ? FORCE_MASK : '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata <= '0;
         bus_err   <= 1'b0;
      end else begin
         if (bus_rd) bus_rdata <= rd_next;
         bus_err <= (bus_rd || bus_wr) && !in_range;
      end
   end

endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk #(
   parameter int                           ADDR_W         = 12,
   parameter int                           DATA_W         = 32,
   parameter int                           NUM_WORDS      = 512,
   parameter logic [ADDR_W-1:0]            CTRL_OFFSET    = 12'hF00,
   parameter int                           NUM_FORCED     = 3,
   parameter logic [NUM_FORCED*ADDR_W-1:0] FORCED_OFFSETS = {12'h10C, 12'h108, 12'h100},
   parameter logic [DATA_W-1:0]            FORCE_MASK     = 32'h3000_0000
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              sys_reset_req,
   input logic              sys_off_req,
   input logic              bus_err
);

   logic outside, ctl, fhit;

   always_comb begin
      outside = (int'(bus_addr >> 2) >= NUM_WORDS);
      ctl     = ((bus_addr >> 2) == (CTRL_OFFSET >> 2));
      fhit    = 1'b0;
      for (int k = 0; k < NUM_FORCED; k++) begin
         if ((bus_addr >> 2) == (FORCED_OFFSETS[k*ADDR_W +: ADDR_W] >> 2)) fhit = 1'b1;
      end
   end

   a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(sys_reset_req && sys_off_req));

   a_r6_reset_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && ctl && (bus_wdata == DATA_W'(1) || bus_wdata == DATA_W'(2))) |=> sys_reset_req);

   a_r7_off_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && ctl && bus_wdata == DATA_W'(3)) |=> (sys_off_req && !sys_reset_req));

   a_r8_no_request: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && ctl) |=> (!sys_reset_req && !sys_off_req));

   a_r4_outside_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && outside) |=> (bus_rdata == '0));

   a_r10_err_raised: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_rd || bus_wr) && outside) |=> bus_err);

   a_r10_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !((bus_rd || bus_wr) && outside) |=> !bus_err);

   a_r5_forced_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !outside && fhit) |=> ((bus_rdata & FORCE_MASK) == FORCE_MASK));

   a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_rd && $past(rst_n)) |=> $stable(bus_rdata));

endmodule

bind sysctl_regfile sysctl_regfile_chk #(
   .ADDR_W        (ADDR_W),
   .DATA_W        (DATA_W),
   .NUM_WORDS     (NUM_WORDS),
   .CTRL_OFFSET   (CTRL_OFFSET),
   .NUM_FORCED    (NUM_FORCED),
   .FORCED_OFFSETS(FORCED_OFFSETS),
   .FORCE_MASK    (FORCE_MASK)
) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_addr     (bus_addr),
   .bus_rd       (bus_rd),
   .bus_wr       (bus_wr),
   .bus_wdata    (bus_wdata),
   .bus_rdata    (bus_rdata),
   .sys_reset_req(sys_reset_req),
   .sys_off_req  (sys_off_req),
   .bus_err      (bus_err)
);

// File: tb/test_sysctl_regfile.sv
`timescale 1ns/1ps
module test_sysctl_regfile;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        sys_reset_req, sys_off_req, bus_err;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   sysctl_regfile i_sysctl_regfile (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_addr     (bus_addr),
      .bus_rd       (bus_rd),
      .bus_wr       (bus_wr),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .sys_reset_req(sys_reset_req),
      .sys_off_req  (sys_off_req),
      .bus_err      (bus_err)
   );

   // flags field: {reset_req, off_req, err}
   typedef struct packed {
      logic        rd;
      logic [11:0] addr;
      logic [31:0] data;
      logic [31:0] exp;
      logic [2:0]  fl;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 24;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 12'h100, 32'h0,          32'h35F2_0121, 3'b000, 8'd5},  // R1 R5
      '{1'b1, 12'h104, 32'h0,          32'h0000_0002, 3'b000, 8'd5},  // R1 R5 not forced
      '{1'b1, 12'h108, 32'h0,          32'h35F3_0121, 3'b000, 8'd5},  // R1 R5
      '{1'b1, 12'h10C, 32'h0,          32'h35F4_0121, 3'b000, 8'd5},  // R1 R5
      '{1'b1, 12'h000, 32'h0,          32'h0000_0000, 3'b000, 8'd1},  // R1 others zero
      '{1'b0, 12'h010, 32'hA5A5_0F0F,  32'h0,         3'b000, 8'd2},  // R2
      '{1'b1, 12'h010, 32'h0,          32'hA5A5_0F0F, 3'b000, 8'd2},  // R2
      '{1'b0, 12'h7FC, 32'h1234_5678,  32'h0,         3'b000, 8'd3},  // R3 last word
      '{1'b1, 12'h7FC, 32'h0,          32'h1234_5678, 3'b000, 8'd3},  // R3
      '{1'b0, 12'h800, 32'hDEAD_BEEF,  32'h0,         3'b001, 8'd3},  // R3 R10
      '{1'b1, 12'h800, 32'h0,          32'h0000_0000, 3'b001, 8'd4},  // R4 R10
      '{1'b1, 12'h000, 32'h0,          32'h0000_0000, 3'b000, 8'd3},  // R3 no alias
      '{1'b0, 12'h100, 32'h0,          32'h0,         3'b000, 8'd5},  // R5
      '{1'b1, 12'h100, 32'h0,          32'h3000_0000, 3'b000, 8'd5},  // R5
      '{1'b0, 12'h013, 32'hCAFE_F00D,  32'h0,         3'b000, 8'd11}, // R11
      '{1'b1, 12'h010, 32'h0,          32'hCAFE_F00D, 3'b000, 8'd11}, // R11
      '{1'b0, 12'hF00, 32'h1,          32'h0,         3'b101, 8'd6},  // R6 R9
      '{1'b0, 12'hF00, 32'h2,          32'h0,         3'b101, 8'd6},  // R6
      '{1'b0, 12'hF00, 32'h3,          32'h0,         3'b011, 8'd7},  // R7 R12
      '{1'b0, 12'hF00, 32'h4,          32'h0,         3'b001, 8'd8},  // R8
      '{1'b0, 12'hF00, 32'h0,          32'h0,         3'b001, 8'd8},  // R8
      '{1'b1, 12'hF00, 32'h0,          32'h0000_0000, 3'b001, 8'd9},  // R9 R8 R4
      '{1'b0, 12'h004, 32'h1,          32'h0,         3'b000, 8'd8},  // R8 elsewhere
      '{1'b1, 12'hFFC, 32'h0,          32'h0000_0000, 3'b001, 8'd4}   // R4
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   // called at a negedge; returns at the next negedge with outputs settled
   task automatic bus_op(input logic rd, input logic [11:0] a, input logic [31:0] d);
      bus_rd    = rd;
      bus_wr    = ~rd;
      bus_addr  = a;
      bus_wdata = d;
      @(negedge clk);
      bus_rd    = 1'b0;
      bus_wr    = 1'b0;
   endtask

   function automatic logic [31:0] flags();
      return {29'd0, sys_reset_req, sys_off_req, bus_err};
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset rdata", bus_rdata, 32'h0);
      chk("R1 reset flags", flags(), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         bus_op(VEC[i].rd, VEC[i].addr, VEC[i].data);
         if (VEC[i].rd)
            chk($sformatf("R%0d vec %0d rdata", VEC[i].req, i), bus_rdata, VEC[i].exp);
         chk($sformatf("R%0d vec %0d flags", VEC[i].req, i), flags(), {29'd0, VEC[i].fl});
      end

      // R6 pulse lasts one cycle, R10 error clears when idle
      bus_op(1'b0, 12'hF00, 32'h2);
      chk("R6 pulse high", {31'd0, sys_reset_req}, 32'h1);
      @(negedge clk);
      chk("R6 pulse width one cycle", flags(), 32'h0);
      bus_op(1'b0, 12'hF00, 32'h3);
      @(negedge clk);
      chk("R7 pulse width one cycle", flags(), 32'h0);

      // R2 read data held without strobe
      bus_op(1'b1, 12'h010, 32'h0);
      @(negedge clk);
      @(negedge clk);
      chk("R2 rdata held", bus_rdata, 32'hCAFE_F00D);

      // R1 defaults restored by a later reset
      bus_op(1'b0, 12'h104, 32'h55);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      bus_op(1'b1, 12'h104, 32'h0);
      chk("R1 default after reset", bus_rdata, 32'h0000_0002);
      bus_op(1'b1, 12'h010, 32'h0);
      chk("R1 zero after reset", bus_rdata, 32'h0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule